// File: doc/BRIEF.md
# Machine-Check Error Bank Registers

This unit holds a row of error-reporting banks. Each bank keeps a control word of enable bits, a status record and the address that goes with that record. Software reaches every register through one read/write port that carries a register index. Hardware error detectors post error records into a chosen bank. Every posted error is recorded, whatever the enables say. The control word decides only whether an uncorrected error also raises a machine-check exception request toward the core.

Illegal accesses do not complete. They return a protection-fault flag, and no register changes. There are three kinds of illegal access: an access to an index that is not implemented, an access to the address slot of the bank that has no address register, and a nonzero write to a status or address register. A status or address record can only be cleared by writing zero to it. A warm reset clears the enables but keeps every logged record. Only a cold reset clears everything.

The access response is registered: it appears one clock after the request. The exception request also appears one clock after the error post that causes it.

Top module: `mce_bank_array`

## Requirements
- R1: The unit claims indices from 400h up to 400h + 4*NUM_BANKS - 1 (417h for six banks). For a claimed index, the bank is (index - 400h) >> 2 and index bits [1:0] pick the register: 0 is control, 1 is status, 2 is address, 3 is the unimplemented misc slot. One cycle after acc_valid, rsp_valid is 1. For an unclaimed index, rsp_claim, rsp_fault and rsp_rdata are all 0.
- R2: A control register stores only the implemented enable bits (CTL_IMPL_MASK, default 64'hFF). The other bits read as zero even after an all-ones write.
- R3: An access faults when it is one of these: any access to a misc index; any access to index 406h (the address slot of bank 1, which has no address register); a write of a nonzero value to a status or address register. On a fault, rsp_fault is 1, rsp_rdata is 0 and no register changes.
- R4: Writing zero to a status or address register clears it.
- R5: Status layout: bit 63 valid, bit 62 overflow, bit 61 uncorrected, bit 58 address valid, bits [15:0] error code, all other bits 0. A post carrying an address (err_addr_vld) sets bit 58 and loads the address register. Bank 1 never sets bit 58.
- R6: Every post to a bank below NUM_BANKS is recorded, whatever that bank's control bits say.
- R7: mce_req is 1 for exactly the cycle after a post that is uncorrected and whose enable bit is set. The enable bit is control bit err_code[5:0] of the target bank, and it must be implemented. A corrected post never raises the request.
- R8: A post into a valid record sets the overflow bit. An uncorrected post replaces a corrected record, including its address when err_addr_vld is 1. Any other post into a valid record leaves the code, flags and address unchanged.
- R9: While warm_rst_n is low, control registers clear, status and address registers keep their values, accesses get no response, and posts are dropped. cold_rst_n low clears every register.
- R10: If a zero write to a status register and a post to the same bank happen in the same cycle, the record afterwards holds the new error with overflow 0.
- R11: A post to a bank number of NUM_BANKS or more is ignored and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous cold reset, active low, clears everything |
| warm_rst_n | input | 1 | Synchronous warm reset, active low, keeps logged records |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | IDX_W | Register index |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_claim | output | 1 | Index belongs to this unit |
| rsp_fault | output | 1 | Protection fault, access not completed |
| rsp_rdata | output | 64 | Read data, 0 for writes and faults |
| err_valid | input | 1 | Error post strobe |
| err_bank | input | BANK_W | Target bank |
| err_uncorr | input | 1 | Error is uncorrected |
| err_addr_vld | input | 1 | err_addr is meaningful |
| err_code | input | CODE_W | Error code, bits [5:0] select the enable bit |
| err_addr | input | 64 | Faulting memory address |
| mce_req | output | 1 | Machine-check exception request pulse |

## Verification
The bench builds the unit with its default parameters: six banks, base index 400h, bank 1 without an address register, and eight implemented enable bits. The narrow enable mask lets a code of 9 hit an unimplemented enable bit. Bank numbers 6 and 7 fit in the 3-bit bank field, so an out-of-range post can be driven. The small index span lets the bench reach both edges of the claimed range, 3FFh and 418h, next to the misc and missing-address slots.

// File: rtl/mce_pkg.sv
package mce_pkg;
    localparam int XLEN      = 64;
    localparam int ST_VAL    = 63;
    localparam int ST_OVER   = 62;
    localparam int ST_UC     = 61;
    localparam int ST_ADDRV  = 58;
    localparam int CSEL_W    = $clog2(XLEN);

    typedef enum logic [1:0] {
        REG_CTL  = 2'd0,
        REG_STAT = 2'd1,
        REG_ADDR = 2'd2,
        REG_MISC = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] ctl;
        logic [XLEN-1:0] st;
        logic [XLEN-1:0] ad;
    } bank_regs_t;

    typedef struct packed {
        logic            valid;
        logic            claim;
        logic            fault;
        logic [XLEN-1:0] rdata;
        logic            mce;
    } rsp_state_t;
endpackage

// File: rtl/mce_idx_decode.sv
module mce_idx_decode
    import mce_pkg::*;
#(
    parameter int               NUM_BANKS    = 6,
    parameter int               IDX_W        = 12,
    parameter logic [IDX_W-1:0] BASE_IDX     = 12'h400,
    parameter int               NO_ADDR_BANK = 1,
    parameter int               BANK_W       = 3
) (
    input  logic [IDX_W-1:0]  idx,
    output logic              claim,
    output logic [BANK_W-1:0] bank,
    output reg_kind_e         kind,
    output logic              always_fault
);
    localparam int SPAN = 4 * NUM_BANKS;

    logic [IDX_W-1:0] off;

    always_comb begin
        off          = idx - BASE_IDX;
        claim        = (idx >= BASE_IDX) && (off < IDX_W'(SPAN));
        bank         = BANK_W'(off >> 2);
        kind         = reg_kind_e'(off[1:0]);
        always_fault = claim &&
                       ((kind == REG_MISC) ||
                        ((kind == REG_ADDR) && (bank == BANK_W'(NO_ADDR_BANK))));
    end
endmodule

// File: rtl/mce_bank_slot.sv
module mce_bank_slot
    import mce_pkg::*;
#(
    parameter bit              HAS_ADDR  = 1'b1,
    parameter logic [XLEN-1:0] IMPL_MASK = 64'hFF,
    parameter int              CODE_W    = 16
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              warm_rst_n,
    input  logic              ctl_we,
    input  logic [XLEN-1:0]   ctl_wdata,
    input  logic              st_clr,
    input  logic              ad_clr,
    input  logic              post_v,
    input  logic              post_uc,
    input  logic              post_av,
    input  logic [CODE_W-1:0] post_code,
    input  logic [XLEN-1:0]   post_addr,
    output bank_regs_t        regs_o,
    output logic              raise_o
);
    bank_regs_t regs_d, regs_q;
    logic       take;
    logic       was_valid;
    logic       addr_ok;

    always_comb begin
        regs_d  = regs_q;
        addr_ok = post_av && HAS_ADDR;
        // software side first, so a post in the same cycle lands on the cleared record
        if (ctl_we) regs_d.ctl = ctl_wdata & IMPL_MASK;
        if (st_clr) regs_d.st  = '0;
        if (ad_clr) regs_d.ad  = '0;

        was_valid = regs_d.st[ST_VAL];
        take      = !was_valid || (post_uc && !regs_d.st[ST_UC]);

        if (post_v) begin
            if (take) begin
                regs_d.st                     = '0;
                regs_d.st[ST_VAL]             = 1'b1;
                regs_d.st[ST_OVER]            = was_valid;
                regs_d.st[ST_UC]              = post_uc;
                regs_d.st[ST_ADDRV]           = addr_ok;
                regs_d.st[CODE_W-1:0]         = post_code;
                if (addr_ok) regs_d.ad        = post_addr;
            end else begin
                regs_d.st[ST_OVER]            = 1'b1;
            end
        end
        if (!HAS_ADDR) regs_d.ad = '0;

        raise_o = post_v && post_uc && regs_q.ctl[post_code[CSEL_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!cold_rst_n) begin
            regs_q <= '0;
        end else if (!warm_rst_n) begin
            regs_q.ctl <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/mce_bank_array.sv
module mce_bank_array
    import mce_pkg::*;
#(
    parameter int               NUM_BANKS     = 6,
    parameter int               IDX_W         = 12,
    parameter logic [IDX_W-1:0] BASE_IDX      = 12'h400,
    parameter int               NO_ADDR_BANK  = 1,
    parameter logic [63:0]      CTL_IMPL_MASK = 64'hFF,
    parameter int               CODE_W        = 16,
    localparam int              BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS + 1) : 1
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              warm_rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [63:0]       acc_wdata,
    output logic              rsp_valid,
    output logic              rsp_claim,
    output logic              rsp_fault,
    output logic [63:0]       rsp_rdata,
    input  logic              err_valid,
    input  logic [BANK_W-1:0] err_bank,
    input  logic              err_uncorr,
    input  logic              err_addr_vld,
    input  logic [CODE_W-1:0] err_code,
    input  logic [63:0]       err_addr,
    output logic              mce_req
);
    logic              dec_claim;
    logic [BANK_W-1:0] dec_bank;
    reg_kind_e         dec_kind;
    logic              dec_hard_fault;
    logic              acc_fault;
    logic              acc_go;
    logic [XLEN-1:0]   rd_mux;

    bank_regs_t             regs   [NUM_BANKS];
    logic [NUM_BANKS-1:0]   raise_vec;
    logic [NUM_BANKS*XLEN-1:0] st_flat;

    rsp_state_t s_d, s_q;

    mce_idx_decode #(
        .NUM_BANKS   (NUM_BANKS),
        .IDX_W       (IDX_W),
        .BASE_IDX    (BASE_IDX),
        .NO_ADDR_BANK(NO_ADDR_BANK),
        .BANK_W      (BANK_W)
    ) u_dec (
        .idx         (acc_idx),
        .claim       (dec_claim),
        .bank        (dec_bank),
        .kind        (dec_kind),
        .always_fault(dec_hard_fault)
    );

    always_comb begin
        acc_fault = dec_hard_fault ||
                    (dec_claim && acc_write && (|acc_wdata) &&
                     ((dec_kind == REG_STAT) || (dec_kind == REG_ADDR)));
        acc_go    = acc_valid && warm_rst_n && dec_claim && !acc_fault;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        logic post_v;
        assign sel    = acc_go && acc_write && (dec_bank == BANK_W'(b));
        assign post_v = err_valid && warm_rst_n && (err_bank == BANK_W'(b));

        mce_bank_slot #(
            .HAS_ADDR (b != NO_ADDR_BANK),
            .IMPL_MASK(CTL_IMPL_MASK),
            .CODE_W   (CODE_W)
        ) u_slot (
            .clk      (clk),
            .cold_rst_n(cold_rst_n),
            .warm_rst_n(warm_rst_n),
            .ctl_we   (sel && (dec_kind == REG_CTL)),
            .ctl_wdata(acc_wdata),
            .st_clr   (sel && (dec_kind == REG_STAT)),
            .ad_clr   (sel && (dec_kind == REG_ADDR)),
            .post_v   (post_v),
            .post_uc  (err_uncorr),
            .post_av  (err_addr_vld),
            .post_code(err_code),
            .post_addr(err_addr),
            .regs_o   (regs[b]),
            .raise_o  (raise_vec[b])
        );

        assign st_flat[b*XLEN +: XLEN] = regs[b].st;
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec_bank == BANK_W'(b)) begin
                case (dec_kind)
                    REG_CTL:  rd_mux = regs[b].ctl;
                    REG_STAT: rd_mux = regs[b].st;
                    REG_ADDR: rd_mux = regs[b].ad;
                    default:  rd_mux = '0;
                endcase
            end
        end
    end

    always_comb begin
        s_d       = '0;
        s_d.valid = acc_valid;
        s_d.claim = acc_valid && dec_claim;
        s_d.fault = acc_valid && acc_fault;
        if (acc_go && !acc_write) s_d.rdata = rd_mux;
        s_d.mce   = |raise_vec;
    end

    always_ff @(posedge clk) begin
        if (!cold_rst_n || !warm_rst_n) s_q <= '0;
        else                            s_q <= s_d;
    end

    assign rsp_valid = s_q.valid;
    assign rsp_claim = s_q.claim;
    assign rsp_fault = s_q.fault;
    assign rsp_rdata = s_q.rdata;
    assign mce_req   = s_q.mce;
endmodule

// File: rtl/mce_bank_array_chk.sv
module mce_bank_array_chk #(
    parameter int               NUM_BANKS = 6,
    parameter int               IDX_W     = 12,
    parameter logic [IDX_W-1:0] BASE_IDX  = 12'h400
) (
    input logic                    clk,
    input logic                    cold_rst_n,
    input logic                    warm_rst_n,
    input logic                    acc_valid,
    input logic                    acc_write,
    input logic [IDX_W-1:0]        acc_idx,
    input logic [63:0]             acc_wdata,
    input logic                    err_valid,
    input logic                    err_uncorr,
    input logic                    rsp_valid,
    input logic                    rsp_claim,
    input logic                    rsp_fault,
    input logic [63:0]             rsp_rdata,
    input logic                    mce_req,
    input logic [NUM_BANKS*64-1:0] st_flat
);
    localparam logic [IDX_W-1:0] ST0_IDX = BASE_IDX + IDX_W'(1);

    a_r3_fault_no_data: assert property (@(posedge clk) disable iff (!cold_rst_n)
        rsp_fault |-> (rsp_claim && rsp_rdata == 64'd0));

    a_r1_unclaimed_quiet: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (rsp_valid && !rsp_claim) |-> (!rsp_fault && rsp_rdata == 64'd0));

    a_r7_req_has_cause: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        mce_req |-> $past(err_valid && err_uncorr));

    a_r9_warm_keeps_records: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !warm_rst_n |=> $stable(st_flat));

    a_r4_valid_drops_on_clear: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $fell(st_flat[63]) |->
            $past(acc_valid && warm_rst_n && acc_write && acc_idx == ST0_IDX && acc_wdata == 64'd0));
endmodule

bind mce_bank_array mce_bank_array_chk #(
    .NUM_BANKS(NUM_BANKS),
    .IDX_W    (IDX_W),
    .BASE_IDX (BASE_IDX)
) u_chk (
    .clk       (clk),
    .cold_rst_n(cold_rst_n),
    .warm_rst_n(warm_rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_idx   (acc_idx),
    .acc_wdata (acc_wdata),
    .err_valid (err_valid),
    .err_uncorr(err_uncorr),
    .rsp_valid (rsp_valid),
    .rsp_claim (rsp_claim),
    .rsp_fault (rsp_fault),
    .rsp_rdata (rsp_rdata),
    .mce_req   (mce_req),
    .st_flat   (st_flat)
);

// File: tb/mce_bank_array_bench.sv
module mce_bank_array_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [11:0] acc_idx = '0;
    logic [63:0] acc_wdata = '0;
    logic        rsp_valid, rsp_claim, rsp_fault, mce_req;
    logic [63:0] rsp_rdata;
    logic        err_valid = 1'b0;
    logic [2:0]  err_bank = '0;
    logic        err_uncorr = 1'b0;
    logic        err_addr_vld = 1'b0;
    logic [15:0] err_code = '0;
    logic [63:0] err_addr = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mce_bank_array u_mce_bank_array (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_claim(rsp_claim), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .err_valid(err_valid), .err_bank(err_bank), .err_uncorr(err_uncorr),
        .err_addr_vld(err_addr_vld), .err_code(err_code), .err_addr(err_addr),
        .mce_req(mce_req)
    );

    typedef struct packed {
        logic [1:0]  op;      // 0 read, 1 write, 2 post
        logic [11:0] idx;     // index, or bank in [2:0] for a post
        logic [63:0] data;    // write data, or address for a post
        logic        uc;
        logic        av;
        logic [15:0] code;
        logic        e_claim;
        logic        e_fault;
        logic [63:0] e_rdata;
        logic        e_mce;
        logic [7:0]  req;
    } vec_t;

    function automatic vec_t rd(logic [11:0] i, logic c, logic f, logic [63:0] r, logic [7:0] q);
        return '{2'd0, i, 64'd0, 1'b0, 1'b0, 16'd0, c, f, r, 1'b0, q};
    endfunction
    function automatic vec_t wr(logic [11:0] i, logic [63:0] d, logic f, logic [7:0] q);
        return '{2'd1, i, d, 1'b0, 1'b0, 16'd0, 1'b1, f, 64'd0, 1'b0, q};
    endfunction
    function automatic vec_t po(logic [2:0] b, logic u, logic a, logic [15:0] c,
                                logic [63:0] ad, logic m, logic [7:0] q);
        return '{2'd2, {9'd0, b}, ad, u, a, c, 1'b0, 1'b0, 64'd0, m, q};
    endfunction

    localparam int NV = 42;
    localparam vec_t VECS [NV] = '{
        wr(12'h400, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'd2),       // R2 all-ones control
        rd(12'h400, 1'b1, 1'b0, 64'hFF, 8'd2),                  // R2 masked readback
        wr(12'h408, 64'h0F0F, 1'b0, 8'd2),                      // R2
        rd(12'h408, 1'b1, 1'b0, 64'h0F, 8'd2),                  // R2
        rd(12'h401, 1'b1, 1'b0, 64'd0, 8'd1),                   // R1 empty status
        rd(12'h418, 1'b0, 1'b0, 64'd0, 8'd1),                   // R1 just above span
        rd(12'h3FF, 1'b0, 1'b0, 64'd0, 8'd1),                   // R1 just below span
        rd(12'h403, 1'b1, 1'b1, 64'd0, 8'd3),                   // R3 misc read
        wr(12'h417, 64'd0, 1'b1, 8'd3),                         // R3 misc write
        rd(12'h406, 1'b1, 1'b1, 64'd0, 8'd3),                   // R3 bank1 address read
        wr(12'h406, 64'd0, 1'b1, 8'd3),                         // R3 bank1 address write
        rd(12'h40A, 1'b1, 1'b0, 64'd0, 8'd1),                   // R1 bank2 address
        po(3'd0, 1'b0, 1'b1, 16'h0003, 64'h1234, 1'b0, 8'd6),   // R6 corrected, no request
        rd(12'h401, 1'b1, 1'b0, 64'h8400_0000_0000_0003, 8'd5), // R5
        rd(12'h402, 1'b1, 1'b0, 64'h1234, 8'd5),                // R5
        wr(12'h401, 64'd5, 1'b1, 8'd3),                         // R3 nonzero status write
        wr(12'h402, 64'd1, 1'b1, 8'd3),                         // R3 nonzero address write
        rd(12'h401, 1'b1, 1'b0, 64'h8400_0000_0000_0003, 8'd3), // R3 unchanged
        rd(12'h402, 1'b1, 1'b0, 64'h1234, 8'd3),                // R3 unchanged
        po(3'd0, 1'b1, 1'b0, 16'h0005, 64'd0, 1'b1, 8'd7),      // R7 enabled uncorrected
        rd(12'h401, 1'b1, 1'b0, 64'hE000_0000_0000_0005, 8'd8), // R8 replace + overflow
        rd(12'h402, 1'b1, 1'b0, 64'h1234, 8'd8),                // R8 no new address
        po(3'd0, 1'b0, 1'b1, 16'h0007, 64'h9999, 1'b0, 8'd8),   // R8 corrected into valid
        rd(12'h401, 1'b1, 1'b0, 64'hE000_0000_0000_0005, 8'd8), // R8 kept
        rd(12'h402, 1'b1, 1'b0, 64'h1234, 8'd8),                // R8 address kept
        po(3'd0, 1'b1, 1'b0, 16'h0009, 64'd0, 1'b0, 8'd7),      // R7 unimplemented enable bit
        rd(12'h401, 1'b1, 1'b0, 64'hE000_0000_0000_0005, 8'd8), // R8 first uncorrected kept
        wr(12'h401, 64'd0, 1'b0, 8'd4),                         // R4
        rd(12'h401, 1'b1, 1'b0, 64'd0, 8'd4),                   // R4
        wr(12'h402, 64'd0, 1'b0, 8'd4),                         // R4
        rd(12'h402, 1'b1, 1'b0, 64'd0, 8'd4),                   // R4
        po(3'd1, 1'b1, 1'b1, 16'h0002, 64'hABCD, 1'b0, 8'd6),   // R6 disabled bank still logs
        rd(12'h405, 1'b1, 1'b0, 64'hA000_0000_0000_0002, 8'd5), // R5 bank1 never address valid
        wr(12'h404, 64'd3, 1'b0, 8'd2),                         // R2
        po(3'd1, 1'b1, 1'b0, 16'h0001, 64'd0, 1'b1, 8'd7),      // R7
        rd(12'h405, 1'b1, 1'b0, 64'hE000_0000_0000_0002, 8'd8), // R8
        po(3'd7, 1'b1, 1'b0, 16'h0000, 64'd0, 1'b0, 8'd11),     // R11 out-of-range bank
        rd(12'h415, 1'b1, 1'b0, 64'd0, 8'd11),                  // R11 bank5 untouched
        po(3'd2, 1'b1, 1'b1, 16'h0003, 64'h77, 1'b1, 8'd7),     // R7 bank2 bit3 enabled
        rd(12'h409, 1'b1, 1'b0, 64'hA400_0000_0000_0003, 8'd5), // R5
        rd(12'h40A, 1'b1, 1'b0, 64'h77, 8'd5),                  // R5
        po(3'd2, 1'b0, 1'b0, 16'h0001, 64'd0, 1'b0, 8'd7)       // R7 corrected never raises
    };

    task automatic chk(bit ok, int req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        acc_valid = 1'b0; acc_write = 1'b0; acc_idx = '0; acc_wdata = '0;
        err_valid = 1'b0; err_bank = '0; err_uncorr = 1'b0; err_addr_vld = 1'b0;
        err_code = '0; err_addr = '0;
    endtask

    task automatic access(bit w, logic [11:0] i, logic [63:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_idx = i; acc_wdata = d;
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic post(logic [2:0] b, bit u, bit a, logic [15:0] c, logic [63:0] ad);
        @(negedge clk);
        err_valid = 1'b1; err_bank = b; err_uncorr = u; err_addr_vld = a;
        err_code = c; err_addr = ad;
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic read_chk(logic [11:0] i, logic [63:0] exp, int req);
        access(1'b0, i, 64'd0);
        chk(rsp_valid && rsp_claim && !rsp_fault && rsp_rdata == exp, req,
            $sformatf("read %h", i), rsp_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired: actual %0d expected 0", WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        idle_inputs();
        repeat (4) @(posedge clk);
        #1;
        chk(!rsp_valid && !rsp_fault && !mce_req && rsp_rdata == 64'd0, 9,
            "outputs in cold reset", {61'd0, rsp_valid, rsp_fault, mce_req}, 64'd0);
        @(negedge clk); cold_rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            vec_t v = VECS[k];
            @(negedge clk);
            if (v.op == 2'd2) begin
                err_valid = 1'b1; err_bank = v.idx[2:0]; err_uncorr = v.uc;
                err_addr_vld = v.av; err_code = v.code; err_addr = v.data;
            end else begin
                acc_valid = 1'b1; acc_write = v.op[0]; acc_idx = v.idx; acc_wdata = v.data;
            end
            @(posedge clk); #1;
            idle_inputs();
            if (v.op == 2'd2) begin
                chk(mce_req == v.e_mce, int'(v.req), $sformatf("vec %0d mce_req", k),
                    {63'd0, mce_req}, {63'd0, v.e_mce});
            end else begin
                chk(rsp_valid && rsp_claim == v.e_claim && rsp_fault == v.e_fault &&
                    rsp_rdata == v.e_rdata, int'(v.req), $sformatf("vec %0d response", k),
                    rsp_rdata ^ {61'd0, rsp_valid, rsp_claim, rsp_fault},
                    v.e_rdata ^ {61'd0, 1'b1, v.e_claim, v.e_fault});
            end
        end

        // R7: request lasts a single cycle
        @(negedge clk);
        chk(!mce_req, 7, "request one cycle only", {63'd0, mce_req}, 64'd0);

        // R10: zero write and post to the same bank in one cycle
        post(3'd4, 1'b0, 1'b0, 16'h0001, 64'd0);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_idx = 12'h411; acc_wdata = 64'd0;
        err_valid = 1'b1; err_bank = 3'd4; err_uncorr = 1'b0; err_code = 16'h0002;
        @(posedge clk); #1;
        idle_inputs();
        read_chk(12'h411, 64'h8000_0000_0000_0002, 10);

        // R9: warm reset keeps records, clears enables, drops accesses and posts
        access(1'b1, 12'h40C, 64'hFF);
        post(3'd3, 1'b1, 1'b1, 16'h0011, 64'h55);
        @(negedge clk);
        warm_rst_n = 1'b0;
        acc_valid = 1'b1; acc_idx = 12'h40D;
        err_valid = 1'b1; err_bank = 3'd3; err_uncorr = 1'b1; err_code = 16'h0001;
        @(posedge clk); #1;
        chk(!rsp_valid && !mce_req, 9, "no response in warm reset",
            {62'd0, rsp_valid, mce_req}, 64'd0);
        idle_inputs();
        repeat (2) @(posedge clk);
        @(negedge clk); warm_rst_n = 1'b1;
        read_chk(12'h40D, 64'hA400_0000_0000_0011, 9);
        read_chk(12'h40E, 64'h55, 9);
        read_chk(12'h40C, 64'd0, 9);
        read_chk(12'h400, 64'd0, 9);
        post(3'd3, 1'b1, 1'b0, 16'h0000, 64'd0);
        chk(!mce_req, 9, "enables cleared by warm reset", {63'd0, mce_req}, 64'd0);

        // R9: cold reset clears records
        @(negedge clk); cold_rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); cold_rst_n = 1'b1;
        read_chk(12'h40D, 64'd0, 9);
        read_chk(12'h405, 64'd0, 9);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule